// File: doc/BRIEF.md
# Multithreaded Fetch Thread Arbiter

The arbiter decides, every clock cycle, which hardware thread of a multithreaded core is allowed to fetch. Its base rule keeps the threads balanced: the thread holding the fewest instructions between fetch and issue wins. On top of that rule it can hold back threads that are waiting on long-latency loads. It supports three ways of doing this: a plain stall, a stall that waits for a predicted run of memory-level parallelism, and a selective flush of the instructions fetched beyond that predicted run.

The surrounding pipeline reports per-thread events: instructions fetched, instructions leaving the queues, a long-latency load detected (with its instruction tag and a predicted parallelism distance) and a long-latency load completed. The arbiter returns a one-hot grant, a per-thread gate status and a one-cycle flush request naming the thread and the first tag to discard. When every thread is gated, the thread that has waited longest still gets the grant, so fetch never stops completely.

Top module: `fetch_thread_arb`

## Requirements
- R1: `grant_o` always has exactly one bit set.
- R2: The grant goes to the ungated thread with the smallest in-flight count. On equal counts the lowest-numbered thread wins.
- R3: A thread's in-flight count rises by one on a fetch and falls by one on a retire. When both happen in the same cycle, the count does not change. A retire at a count of zero is ignored.
- R4: The arbiter keeps a count of outstanding long-latency loads for each thread. In stall mode a thread is gated while that count is non-zero, and one completion of two outstanding loads leaves the thread gated.
- R5: In MLP-aware stall mode, a thread with outstanding loads is gated once it has fetched at least the distance d predicted with the first load of its burst. Fetches made in the cycle the burst starts are not counted.
- R6: In MLP-aware flush mode, a thread whose burst has fetched more than d instructions requests a flush with tag = (first-load tag + d + 1) mod 2^TAG_W. The thread is not gated before the flush. After its flush is issued, it stays gated until all its loads complete.
- R7: At most one flush is issued per cycle, and the lowest-numbered requesting thread wins. Each thread is flushed once per burst, as a one-cycle pulse. A thread that loses waits for a later cycle.
- R8: When every thread is gated, the grant goes to the oldest thread. At reset the ages run from thread 0 (oldest) upward. A thread that starts a new burst becomes the youngest, and if several start in the same cycle only the lowest-numbered one moves.
- R9: `mode_i` uses the encoding 0 = balance only (never gated), 1 = stall, 2 = MLP-aware stall, 3 = MLP-aware flush. It is taken in only in cycles where no thread has a load outstanding.
- R10: When a thread's last outstanding load completes, its fetch-since-burst count and its flush status are cleared, so the next burst starts fresh.
- R11: After reset thread 0 is granted, no thread is gated and no flush is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy select (R9 encoding) |
| fetch_i | input | N | Per-thread instruction fetched |
| retire_i | input | N | Per-thread instruction left queues |
| ld_det_i | input | N | Per-thread long-latency load detected |
| ld_tag_i | input | N*TAG_W | Tag of the detected load, thread i at slice i |
| ld_dist_i | input | N*DIST_W | Predicted parallelism distance, thread i at slice i |
| ld_done_i | input | N | Per-thread long-latency load completed |
| grant_o | output | N | One-hot fetch grant |
| gated_o | output | N | Per-thread fetch gate |
| flush_valid_o | output | 1 | Flush request pulse |
| flush_tid_o | output | TID_W | Thread to flush |
| flush_tag_o | output | TAG_W | First tag to discard |

## Verification
The bench targets equal in-flight counts, a retire at zero, a fetch and a retire in the same cycle, and a second load inside a burst. A design that got these wrong would grant a higher-numbered thread on a tie, wrap a count to its maximum, or release a thread after only one of two loads completed. It also changes `mode_i` while a load is outstanding: a design that takes the new value at once would drop the gate early. Two threads are made to request a flush in the same cycle, and the tag arithmetic is checked. A faulty arbiter would drop the losing request, repeat a pulse or point at the wrong tag. Finally, every thread is gated in a known order of burst starts, which exposes age tracking that picks a thread other than the one that has waited longest.

// File: rtl/fetch_arb_pkg.sv
package fetch_arb_pkg;
  typedef enum logic [1:0] {
    POL_BALANCE   = 2'd0,
    POL_STALL     = 2'd1,
    POL_MLP_STALL = 2'd2,
    POL_MLP_FLUSH = 2'd3
  } policy_e;
endpackage

// File: rtl/fetch_thread_ctx.sv
module fetch_thread_ctx
  import fetch_arb_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DIST_W = 8,
  parameter int TAG_W  = 8,
  parameter int LD_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  policy_e           policy_i,
  input  logic              fetch_i,
  input  logic              retire_i,
  input  logic              ld_det_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [DIST_W-1:0] ld_dist_i,
  input  logic              ld_done_i,
  input  logic              flush_ack_i,
  output logic [CNT_W-1:0]  inflight_o,
  output logic              busy_o,
  output logic              start_o,
  output logic              gated_o,
  output logic              flush_req_o,
  output logic [TAG_W-1:0]  flush_tag_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [LD_W-1:0]   LD_MAX   = '1;
  localparam logic [DIST_W-1:0] SINCE_MAX = '1;

  logic [CNT_W-1:0]  inflight_q, inflight_d;
  logic [LD_W-1:0]   ld_cnt_q, ld_cnt_d;
  logic [DIST_W-1:0] since_q, since_d, dist_q;
  logic [TAG_W-1:0]  tag_q;
  logic              flushed_q, flushed_d;
  logic              busy, done_eff;

  assign busy     = (ld_cnt_q != '0);
  assign done_eff = ld_done_i && busy;
  assign start_o  = ld_det_i && !busy;

  always_comb begin
    inflight_d = inflight_q;
    if (fetch_i && !retire_i) begin
      if (inflight_q != CNT_MAX) inflight_d = inflight_q + 1'b1;
    end else if (retire_i && !fetch_i && inflight_q != '0) begin
      inflight_d = inflight_q - 1'b1;
    end
  end

  always_comb begin
    ld_cnt_d = ld_cnt_q;
    if (ld_det_i && !done_eff) begin
      if (ld_cnt_q != LD_MAX) ld_cnt_d = ld_cnt_q + 1'b1;
    end else if (!ld_det_i && done_eff) begin
      ld_cnt_d = ld_cnt_q - 1'b1;
    end
  end

  always_comb begin
    since_d   = since_q;
    flushed_d = flushed_q;
    if (ld_cnt_d == '0) begin
      since_d   = '0;
      flushed_d = 1'b0;
    end else begin
      if (busy && fetch_i && since_q != SINCE_MAX) since_d = since_q + 1'b1;
      if (flush_ack_i) flushed_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inflight_q <= '0;
      ld_cnt_q   <= '0;
      since_q    <= '0;
      dist_q     <= '0;
      tag_q      <= '0;
      flushed_q  <= 1'b0;
    end else begin
      inflight_q <= inflight_d;
      ld_cnt_q   <= ld_cnt_d;
      since_q    <= since_d;
      flushed_q  <= flushed_d;
      if (start_o) begin
        dist_q <= ld_dist_i;
        tag_q  <= ld_tag_i;
      end
    end
  end

  always_comb begin
    unique case (policy_i)
      POL_STALL:     gated_o = busy;
      POL_MLP_STALL: gated_o = busy && (since_q >= dist_q);
      POL_MLP_FLUSH: gated_o = busy && flushed_q;
      default:       gated_o = 1'b0;
    endcase
  end

  assign flush_req_o = (policy_i == POL_MLP_FLUSH) && busy && !flushed_q && (since_q > dist_q);
  assign flush_tag_o = tag_q + TAG_W'(dist_q) + TAG_W'(1);
  assign inflight_o  = inflight_q;
  assign busy_o      = busy;

  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inflight_q == '0 && retire_i && !fetch_i) |=> (inflight_q == '0));
  p_fetch_retire_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && retire_i) |=> $stable(inflight_q));
  p_release_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cnt_q == LD_W'(1) && ld_done_i && !ld_det_i) |=> (since_q == '0 && !flushed_q && !busy));
  p_flush_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_ack_i && !ld_done_i) |=> !flush_req_o);
endmodule

// File: rtl/fetch_age_order.sv
module fetch_age_order #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] start_i,
  output logic [N-1:0] oldest_o
);
  logic [IDX_W-1:0] rank_q [N];
  logic [IDX_W-1:0] sel;
  logic             found;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (start_i[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (found) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == sel) rank_q[i] <= IDX_W'(N - 1);
        else if (rank_q[i] > rank_q[sel]) rank_q[i] <= rank_q[i] - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest_o[g] = (rank_q[g] == '0);
  end

  p_oldest_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest_o) == 1);
endmodule

// File: rtl/fetch_pick_min.sv
module fetch_pick_min #(
  parameter int N     = 4,
  parameter int CNT_W = 8
) (
  input  logic [N*CNT_W-1:0] inflight_i,
  input  logic [N-1:0]       gated_i,
  input  logic [N-1:0]       oldest_i,
  output logic [N-1:0]       grant_o
);
  logic [CNT_W-1:0] best;
  logic             found;

  always_comb begin
    found   = 1'b0;
    best    = '0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!gated_i[i] && (!found || inflight_i[i*CNT_W +: CNT_W] < best)) begin
        found      = 1'b1;
        best       = inflight_i[i*CNT_W +: CNT_W];
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
    if (!found) grant_o = oldest_i;
  end
endmodule

// File: rtl/fetch_thread_arb.sv
module fetch_thread_arb
  import fetch_arb_pkg::*;
#(
  parameter int N      = 4,
  parameter int CNT_W  = 8,
  parameter int DIST_W = 8,
  parameter int TAG_W  = 8,
  parameter int LD_W   = 3,
  localparam int TID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic [N-1:0]        fetch_i,
  input  logic [N-1:0]        retire_i,
  input  logic [N-1:0]        ld_det_i,
  input  logic [N*TAG_W-1:0]  ld_tag_i,
  input  logic [N*DIST_W-1:0] ld_dist_i,
  input  logic [N-1:0]        ld_done_i,
  output logic [N-1:0]        grant_o,
  output logic [N-1:0]        gated_o,
  output logic                flush_valid_o,
  output logic [TID_W-1:0]    flush_tid_o,
  output logic [TAG_W-1:0]    flush_tag_o
);
  policy_e            policy_q;
  logic [N-1:0]       busy, start, flush_req, flush_ack, oldest;
  logic [N*CNT_W-1:0] inflight_flat;
  logic [TAG_W-1:0]   flush_tag_v [N];

  // policy changes only when no burst is open anywhere
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) policy_q <= POL_BALANCE;
    else if (busy == '0) policy_q <= policy_e'(mode_i);
  end

  for (genvar g = 0; g < N; g++) begin : g_thr
    fetch_thread_ctx #(
      .CNT_W(CNT_W), .DIST_W(DIST_W), .TAG_W(TAG_W), .LD_W(LD_W)
    ) u_ctx (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .policy_i    (policy_q),
      .fetch_i     (fetch_i[g]),
      .retire_i    (retire_i[g]),
      .ld_det_i    (ld_det_i[g]),
      .ld_tag_i    (ld_tag_i[g*TAG_W +: TAG_W]),
      .ld_dist_i   (ld_dist_i[g*DIST_W +: DIST_W]),
      .ld_done_i   (ld_done_i[g]),
      .flush_ack_i (flush_ack[g]),
      .inflight_o  (inflight_flat[g*CNT_W +: CNT_W]),
      .busy_o      (busy[g]),
      .start_o     (start[g]),
      .gated_o     (gated_o[g]),
      .flush_req_o (flush_req[g]),
      .flush_tag_o (flush_tag_v[g])
    );
  end

  fetch_age_order #(.N(N), .IDX_W(TID_W)) u_age (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .oldest_o (oldest)
  );

  fetch_pick_min #(.N(N), .CNT_W(CNT_W)) u_pick (
    .inflight_i (inflight_flat),
    .gated_i    (gated_o),
    .oldest_i   (oldest),
    .grant_o    (grant_o)
  );

  always_comb begin
    flush_valid_o = 1'b0;
    flush_tid_o   = '0;
    flush_tag_o   = '0;
    flush_ack     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (flush_req[i]) begin
        flush_valid_o = 1'b1;
        flush_tid_o   = TID_W'(i);
        flush_tag_o   = flush_tag_v[i];
        flush_ack     = '0;
        flush_ack[i]  = 1'b1;
      end
    end
  end

  p_grant_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == 1);
  p_grant_eligible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~gated_o != '0) |-> ((grant_o & ~gated_o) != '0));
  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy != '0) |=> (policy_q == $past(policy_q)));
  p_flush_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_valid_o |=> !(flush_valid_o && flush_tid_o == $past(flush_tid_o)));
endmodule

// File: tb/fetch_thread_arb_bench.sv
`timescale 1ns/1ps
module fetch_thread_arb_bench;
  localparam int N = 4;
  localparam int TAG_W = 8;
  localparam int DIST_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [N-1:0] fetch_i = '0, retire_i = '0, ld_det_i = '0, ld_done_i = '0;
  logic [N*TAG_W-1:0] ld_tag_i = '0;
  logic [N*DIST_W-1:0] ld_dist_i = '0;
  logic [N-1:0] grant_o, gated_o;
  logic flush_valid_o;
  logic [1:0] flush_tid_o;
  logic [TAG_W-1:0] flush_tag_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk_i = ~clk_i;

  fetch_thread_arb u_fetch_thread_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .fetch_i(fetch_i),
    .retire_i(retire_i), .ld_det_i(ld_det_i), .ld_tag_i(ld_tag_i),
    .ld_dist_i(ld_dist_i), .ld_done_i(ld_done_i), .grant_o(grant_o),
    .gated_o(gated_o), .flush_valid_o(flush_valid_o),
    .flush_tid_o(flush_tid_o), .flush_tag_o(flush_tag_o)
  );

  // {fetch, retire, expected grant}, walked from reset in mode 0
  localparam logic [11:0] VEC [9] = '{
    {4'b0001, 4'b0000, 4'b0010},
    {4'b0010, 4'b0000, 4'b0100},
    {4'b1100, 4'b0000, 4'b0001},
    {4'b0001, 4'b0001, 4'b0001},
    {4'b0000, 4'b0010, 4'b0010},
    {4'b0000, 4'b0010, 4'b0010},
    {4'b0110, 4'b0000, 4'b0001},
    {4'b0000, 4'b0001, 4'b0001},
    {4'b0001, 4'b1000, 4'b1000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    fetch_i = '0; retire_i = '0; ld_det_i = '0; ld_done_i = '0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_ni = 1'b0;
    mode_i = m;
    @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    @(posedge clk_i);
    #1;
    chk("R11 grant", 32'(grant_o), 32'b0001);
    chk("R11 gated", 32'(gated_o), 32'b0);
    chk("R11 flush", 32'(flush_valid_o), 32'b0);
    rst_ni = 1'b1;
    tick();

    // R2 R3 table in balance mode
    foreach (VEC[k]) begin
      fetch_i  = VEC[k][11:8];
      retire_i = VEC[k][7:4];
      tick();
      chk($sformatf("R2/R3 vec%0d", k), 32'(grant_o), 32'(VEC[k][3:0]));
      chk("R1 onehot", 32'($countones(grant_o)), 32'd1);
    end

    // R9 balance mode never gates
    ld_det_i = 4'b0001;
    tick();
    chk("R9 mode0 no gate", 32'(gated_o), 32'b0);

    // R4 stall mode, two loads, R9 mode held while busy
    do_reset(2'd1);
    ld_det_i = 4'b0001;
    tick();
    chk("R4 stall gate", 32'(gated_o), 32'b0001);
    chk("R4 grant skips gated", 32'(grant_o), 32'b0010);
    ld_det_i = 4'b0001;
    tick();
    mode_i = 2'd0;
    ld_done_i = 4'b0001;
    tick();
    chk("R4/R9 still gated", 32'(gated_o), 32'b0001);
    mode_i = 2'd1;
    ld_done_i = 4'b0001;
    tick();
    chk("R4 released", 32'(gated_o), 32'b0000);

    // R8 all gated -> oldest
    do_reset(2'd1);
    ld_det_i = 4'b0100; tick();
    ld_det_i = 4'b0001; tick();
    ld_det_i = 4'b1000; tick();
    ld_det_i = 4'b0010; tick();
    chk("R8 all gated", 32'(gated_o), 32'b1111);
    chk("R8 oldest grant", 32'(grant_o), 32'b0100);
    ld_done_i = 4'b0010;
    tick();
    chk("R8 released thread", 32'(grant_o), 32'b0010);

    // R5 MLP-aware stall, R10 fresh burst
    do_reset(2'd2);
    ld_det_i = 4'b0010; ld_dist_i = 32'h0000_0200; fetch_i = 4'b0010;
    tick();
    chk("R5 open at 0", 32'(gated_o), 32'b0);
    fetch_i = 4'b0010; tick();
    chk("R5 open at 1", 32'(gated_o), 32'b0);
    fetch_i = 4'b0010; tick();
    chk("R5 gated at d", 32'(gated_o), 32'b0010);
    ld_done_i = 4'b0010; tick();
    chk("R10 released", 32'(gated_o), 32'b0);
    ld_det_i = 4'b0010; ld_dist_i = 32'h0000_0100; tick();
    chk("R10 fresh count", 32'(gated_o), 32'b0);
    fetch_i = 4'b0010; tick();
    chk("R10 new distance", 32'(gated_o), 32'b0010);

    // R6 R7 MLP-aware flush
    do_reset(2'd3);
    ld_det_i = 4'b0111;
    ld_tag_i = {8'd0, 8'd40, 8'd20, 8'd10};
    ld_dist_i = {8'd0, 8'd0, 8'd0, 8'd1};
    tick();
    chk("R6 no flush yet", 32'(flush_valid_o), 32'b0);
    fetch_i = 4'b0111; tick();
    chk("R6 not gated before flush", 32'(gated_o), 32'b0);
    chk("R7 flush valid", 32'(flush_valid_o), 32'd1);
    chk("R7 lowest wins", 32'(flush_tid_o), 32'd1);
    chk("R6 tag", 32'(flush_tag_o), 32'd21);
    tick();
    chk("R7 loser next", 32'(flush_tid_o), 32'd2);
    chk("R6 tag t2", 32'(flush_tag_o), 32'd41);
    chk("R6 flushed gated", 32'(gated_o), 32'b0010);
    tick();
    chk("R7 pulse ends", 32'(flush_valid_o), 32'd0);
    fetch_i = 4'b0001; tick();
    chk("R6 beyond d", 32'(flush_tid_o), 32'd0);
    chk("R6 tag t0", 32'(flush_tag_o), 32'd12);
    tick();
    chk("R6 three gated", 32'(gated_o), 32'b0111);
    chk("R2 only eligible", 32'(grant_o), 32'b1000);
    ld_done_i = 4'b0111; tick();
    chk("R10 flush cleared", 32'(gated_o), 32'b0);
    chk("R10 no flush", 32'(flush_valid_o), 32'd0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule